// File: doc/BRIEF.md
# Serial EEPROM Word-Write Host Controller

This block acts as the host-side master for a three-wire serial EEPROM. A single request holds a 9-bit word address and a 16-bit data word. The block turns that request into a write command frame. It shifts the frame out on a divided serial clock, then releases the chip select so that the device starts its internal programming cycle.

The block does not wait a fixed worst-case time for the programming cycle. After a short pause it raises the select line again with the data line held low. It then watches the device's serial output, which stays low while the device is busy and goes high once the write has completed. When the device reports completion, the block drops the select line and gives a one-cycle completion pulse. If the device stays busy beyond a configurable limit (10 ms by default), the block drops the select line and gives a one-cycle error pulse instead.

Requests are accepted only while the block is idle, so no new command can reach the device before it has reported completion.

Top module: `mwr_write_ctrl`

## Requirements
- R1: One frame carries 29 bits, sampled by the device on SCLK rising edges while select is high. The bits are sent in this order: a 1 (start), the opcode bits 0 then 1, a padding bit sent as 0, address bits 8 down to 0, and data bits 15 down to 0.
- R2: The data line changes only while SCLK is low. It holds its value for the whole of every SCLK high phase inside a frame.
- R3: SCLK high and low phases each last exactly SK_HALF system clocks during a frame. SCLK is low whenever no frame is being shifted.
- R4: After the last frame bit, select stays low for at least 2*SK_HALF system clocks before it rises for the verify phase.
- R5: Throughout the verify phase (select high after the frame), the data line and SCLK are both held low.
- R6: When the synchronized device output is seen high during verify, select goes low. One cycle later done pulses and busy is low.
- R7: If the device output stays low for TIMEOUT_CYCLES clocks of verify, select goes low and error pulses instead of done. Select is therefore high for exactly TIMEOUT_CYCLES clocks of verify.
- R8: start is taken only when busy is low. A start accepted while idle raises busy and select on the next clock. A start given while busy has no effect on the frame being sent or on the outcome.
- R9: Synchronous reset, whether given at start-up or in the middle of a transfer, forces select, SCLK, data, busy, done and error low.
- R10: done and error are each single-cycle pulses, and only one of them is given per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a write (taken only when idle) |
| addr_i | input | 9 | Word address of the request |
| data_i | input | 16 | Data word of the request |
| busy_o | output | 1 | High from acceptance until the result pulse |
| done_o | output | 1 | One-cycle pulse: write confirmed |
| err_o | output | 1 | One-cycle pulse: device stayed busy too long |
| ser_sel_o | output | 1 | Device chip select |
| ser_clk_o | output | 1 | Serial clock to the device |
| ser_dat_o | output | 1 | Serial data to the device |
| mem_dout_i | input | 1 | Serial data/status from the device |

## Verification
The hardest situation to reach from the ports is the timeout path. It can only happen after a complete frame and the enforced pause, with the device still reporting busy for the whole verify window. A device model in the bench captures each frame and keeps its output low for a chosen number of clocks after the select line falls. The bench shrinks TIMEOUT_CYCLES to 200 and programs a busy time longer than that, so the error path is reached and its exact length can be measured. Start requests are also injected while a frame and a verify window are in progress, to show that they are ignored.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    localparam int ADDR_W  = 9;
    localparam int DATA_W  = 16;
    localparam int HDR_W   = 4;
    localparam int FRAME_W = HDR_W + ADDR_W + DATA_W;

    // start bit, opcode 0-1, padding bit driven as 0
    localparam logic [HDR_W-1:0] WR_HDR = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_VERIFY,
        ST_CLOSE
    } mwr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mwr_req_t;

    typedef logic [FRAME_W-1:0] mwr_frame_t;

    function automatic mwr_frame_t build_frame(input mwr_req_t r);
        return {WR_HDR, r.addr, r.data};
    endfunction

endpackage

// File: rtl/mwr_sk_gen.sv
module mwr_sk_gen #(
    parameter int HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sk_o,
    output logic fall_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          sk_q;
    logic          term;

    assign term   = run_i && (cnt_q == TERM);
    assign fall_o = term && sk_q;
    assign sk_o   = sk_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
            sk_q  <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            sk_q  <= ~sk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    sk_halfperiod_chk: assert property (@(posedge clk) disable iff (rst)
        (run_i && !term) |=> $stable(sk_q));

endmodule

// File: rtl/mwr_shifter.sv
module mwr_shifter
    import mwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  mwr_req_t req_i,
    input  logic     shift_i,
    output logic     bit_o,
    output logic     last_o
);
    localparam int LW = $clog2(FRAME_W + 1);

    mwr_frame_t    sreg_q;
    logic [LW-1:0] left_q;

    assign bit_o  = sreg_q[FRAME_W-1];
    assign last_o = (left_q == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sreg_q <= build_frame(req_i);
            left_q <= LW'(FRAME_W);
        end else if (shift_i && left_q != '0) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    // R1
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        left_q <= LW'(FRAME_W));

endmodule

// File: rtl/mwr_cycle_timer.sv
module mwr_cycle_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign hit_o = (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (en_i && !hit_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/mwr_sync.sv
module mwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg_q[0] <= 1'b0;
                    else     stg_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg_q[g] <= 1'b0;
                    else     stg_q[g] <= stg_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mwr_write_ctrl.sv
module mwr_write_ctrl
    import mwr_pkg::*;
#(
    parameter int SK_HALF        = 25,
    parameter int TIMEOUT_CYCLES = 500000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              ser_sel_o,
    output logic              ser_clk_o,
    output logic              ser_dat_o,
    input  logic              mem_dout_i
);
    localparam int GAP_CYCLES = 2 * SK_HALF;

    mwr_state_e st_q;
    logic       sel_q;
    logic       done_q;
    logic       err_q;
    logic       fail_q;

    logic       sk_fall;
    logic       sh_bit;
    logic       sh_last;
    logic       gap_hit;
    logic       tmo_hit;
    logic       dout_s;
    logic       take;
    mwr_req_t   req;

    assign take     = (st_q == ST_IDLE) && start_i;
    assign req.addr = addr_i;
    assign req.data = data_i;

    mwr_sk_gen #(.HALF(SK_HALF)) u_skgen (
        .clk    (clk),
        .rst    (rst),
        .run_i  (st_q == ST_SHIFT),
        .sk_o   (ser_clk_o),
        .fall_o (sk_fall)
    );

    mwr_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (take),
        .req_i   (req),
        .shift_i (sk_fall && st_q == ST_SHIFT),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    mwr_cycle_timer #(.LIMIT(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .clr_i (st_q != ST_GAP),
        .en_i  (st_q == ST_GAP),
        .hit_o (gap_hit)
    );

    mwr_cycle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
        .clk   (clk),
        .rst   (rst),
        .clr_i (st_q != ST_VERIFY),
        .en_i  (st_q == ST_VERIFY && !dout_s),
        .hit_o (tmo_hit)
    );

    mwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (mem_dout_i),
        .q_o (dout_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sel_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q  <= ST_SHIFT;
                        sel_q <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (sk_fall && sh_last) begin
                        st_q  <= ST_GAP;
                        sel_q <= 1'b0;
                    end
                end
                ST_GAP: begin
                    if (gap_hit) begin
                        st_q  <= ST_VERIFY;
                        sel_q <= 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (dout_s) begin
                        st_q   <= ST_CLOSE;
                        sel_q  <= 1'b0;
                        fail_q <= 1'b0;
                    end else if (tmo_hit) begin
                        st_q   <= ST_CLOSE;
                        sel_q  <= 1'b0;
                        fail_q <= 1'b1;
                    end
                end
                ST_CLOSE: begin
                    done_q <= !fail_q;
                    err_q  <= fail_q;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (st_q != ST_IDLE);
    assign done_o    = done_q;
    assign err_o     = err_q;
    assign ser_sel_o = sel_q;
    assign ser_dat_o = (st_q == ST_SHIFT) && sh_bit;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    // R6
    done_sel_low_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |-> (!ser_sel_o && !busy_o));

    // R3
    sk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ser_clk_o);

    // R2
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_sel_o && ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_dat_o));

    // R5
    verify_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_VERIFY) |-> (!ser_dat_o && !ser_clk_o && ser_sel_o));

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && ser_sel_o));

endmodule

// File: tb/test_mwr_write_ctrl.sv
module test_mwr_write_ctrl;

    localparam int SK_HALF = 3;
    localparam int TMO     = 200;
    localparam int NVEC    = 5;

    // {addr[8:0], data[15:0], device busy clocks[15:0], expect error}
    localparam logic [41:0] VEC [NVEC] = '{
        {9'h1FF, 16'hFFFF, 16'd0,   1'b0},
        {9'h000, 16'h0000, 16'd40,  1'b0},
        {9'h155, 16'hA5C3, 16'd120, 1'b0},
        {9'h0AA, 16'h5A3C, 16'd400, 1'b1},
        {9'h100, 16'h0001, 16'd170, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] data = '0;
    logic        mem_dout = 1'b1;
    logic        busy, done, err, sel, sclk, sdat;

    always #10 clk = ~clk;

    mwr_write_ctrl #(
        .SK_HALF(SK_HALF), .TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2)
    ) i_mwr_write_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .addr_i(addr), .data_i(data),
        .busy_o(busy), .done_o(done), .err_o(err),
        .ser_sel_o(sel), .ser_clk_o(sclk), .ser_dat_o(sdat),
        .mem_dout_i(mem_dout)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // device model and monitor
    int          phase = 0;
    logic [63:0] cap;
    int          nbits, busy_cnt, busy_cfg, gap_len, ver_len, run, frames;
    int          dones, errs;
    bit          prev_sk, prev_cs, prev_di;
    bit          sk_bad, di_bad, ver_bad, drop_ready, order_bad;

    always @(negedge clk) begin
        if (rst) begin
            phase = 0; busy_cnt = 0; mem_dout <= 1'b1;
            prev_sk = 0; prev_cs = 0; prev_di = 0;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            if (done) begin dones++; if (sel || prev_cs) order_bad = 1; end
            if (err)  begin errs++;  if (sel || prev_cs) order_bad = 1; end
            case (phase)
                0: begin
                    if (sel && !prev_cs) begin
                        cap = '0; nbits = 0; run = 1;
                    end else if (sel || prev_cs) begin
                        if (sclk != prev_sk) begin
                            if (run != SK_HALF) sk_bad = 1;
                            run = 1;
                        end else run++;
                    end
                    if (sel && sclk && !prev_sk) begin
                        cap = {cap[62:0], sdat}; nbits++;
                    end
                    if (sel && sclk && prev_sk && sdat != prev_di) di_bad = 1;
                    if (!sel && prev_cs) begin
                        phase = 1; frames++; busy_cnt = busy_cfg; gap_len = 1;
                    end
                end
                1: begin
                    if (!sel) gap_len++;
                    else begin
                        phase = 2; ver_len = 1;
                        if (sclk || sdat) ver_bad = 1;
                    end
                end
                default: begin
                    if (sel) begin
                        ver_len++;
                        if (sclk || sdat) ver_bad = 1;
                    end else begin
                        phase = 0; drop_ready = mem_dout;
                    end
                end
            endcase
            mem_dout <= (busy_cnt == 0);
            prev_sk = sclk; prev_cs = sel; prev_di = sdat;
        end
    end

    longint cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_write(input logic [8:0] a, input logic [15:0] d,
                             input int bcyc, input bit exp_err, input bit inject);
        logic [28:0] exp_frame;
        int          f0;
        while (busy_cnt != 0 || phase != 0) @(negedge clk);
        exp_frame = {4'b1010, a, d};
        busy_cfg = bcyc; dones = 0; errs = 0; f0 = frames;
        sk_bad = 0; di_bad = 0; ver_bad = 0; order_bad = 0; drop_ready = 0;
        addr = a; data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8 accepted while idle
        check(busy && sel, "R8", "accept busy/sel", {busy, sel}, 2'b11);
        for (int i = 0; i < 5000 && (dones + errs) == 0; i++) begin
            if (inject && (i == 20 || i == 190)) begin
                start = 1'b1; addr = ~a; data = ~d;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(nbits == 29, "R1", "bit count", nbits, 29);
        check(cap[28:0] == exp_frame, "R1", "frame", cap[28:0], exp_frame);
        check(!di_bad, "R2", "data change in SCLK high", di_bad, 0);
        check(!sk_bad, "R3", "SCLK half period", sk_bad, 0);
        check(gap_len >= 2 * SK_HALF, "R4", "select gap", gap_len, 2 * SK_HALF);
        check(!ver_bad, "R5", "verify lines quiet", ver_bad, 0);
        check(!order_bad, "R6", "select low before result", order_bad, 0);
        if (!exp_err) begin
            check(dones == 1 && errs == 0, "R6", "done pulse", {dones[7:0], errs[7:0]}, 16'h0100);
            check(drop_ready, "R6", "device ready at select drop", drop_ready, 1);
        end else begin
            check(errs == 1 && dones == 0, "R7", "error pulse", {dones[7:0], errs[7:0]}, 16'h0001);
            check(ver_len == TMO, "R7", "verify length", ver_len, TMO);
        end
        // R10 one result, single cycle (counted per sampled high cycle)
        check(dones + errs == 1, "R10", "result pulses", dones + errs, 1);
        check(frames == f0 + 1 && !busy && !sel, "R8", "single frame, idle after",
              frames - f0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check({sel, sclk, sdat, busy, done, err} == 6'b0, "R9", "reset outputs",
              {sel, sclk, sdat, busy, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_write(VEC[v][41:33], VEC[v][32:17], int'(VEC[v][16:1]), VEC[v][0], 1'b0);
        end

        // R8 starts during frame and verify are ignored
        run_write(9'h0F3, 16'h3C5A, 60, 1'b0, 1'b1);

        // R9 reset in the middle of a frame
        addr = 9'h123; data = 16'hBEEF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check({sel, sclk, sdat, busy, done, err} == 6'b0, "R9", "mid-frame reset",
              {sel, sclk, sdat, busy, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        run_write(9'h0C3, 16'h8001, 10, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule